// File: doc/BRIEF.md
# Command Queue Virtualization Configuration Register File

This block is the configuration page of a command-queue virtualization unit. Software reaches it through a plain 32-bit register port: a byte address, write data, a write strobe, a read strobe and registered read data. The page holds the global switch and batching controls, a constant capability word, global and per-interface status, interrupt-mask words, an allocation entry for each physical queue, and the registers of a single virtual interface. The interface registers are its control word, its status word and sixteen pairs of stream-ID match and replace entries.

The unit's enable switches are copied into status bits when they are written, so software can poll for the acknowledgement. The interface's hypervisor-ownership bit is always forced to zero, so the interface can never be claimed by a guest write. The error-map words have no source inside this block and always read as zero. Every offset that is not mapped returns zero on a read and ignores writes. This includes offsets that are not word aligned and offsets at or beyond the 64 KiB page.

Top module: `cqv_cfg_regs`

## Requirements
- R1: After reset every readable word reads 0, except the capability word at 0x4.
- R2: The capability word at 0x4 reads 0x00004011 and ignores writes. Its fields are version in bits 3:0 (1), log2 queue count in bits 7:4 (1), log2 interface count in bits 11:8 (0) and log2 stream IDs per interface in bits 15:12 (4).
- R3: A write to the global control word at 0x0 stores the full 32-bit value. The same write sets bit 0 of the global status word at 0x8 to the written bit 0. The other status bits read 0, and direct writes to 0x8 are ignored.
- R4: The interrupt-mask words at 0x1C and 0x20 store full 32-bit writes. The global error words at 0x14, 0x18 and 0x24 to 0x30 read 0 and ignore writes.
- R5: The queue allocation entries at 0x200 and 0x204 store full 32-bit writes, independently of each other.
- R6: The interface control word at 0x1000 stores every written bit except bit 17 (hypervisor ownership), which always reads 0.
- R7: Bit 0 of the interface status word at 0x1004 follows bit 0 of the last write to 0x1000. Its other bits read 0, and direct writes to it are ignored.
- R8: The sixteen match entries at 0x1040+4j and the sixteen replace entries at 0x1080+4j (j = 0..15) each store full 32-bit writes independently.
- R9: The interface error words at 0x10C0 to 0x10CC read 0 and ignore writes.
- R10: Reads from unmapped, unaligned (address bits 1:0 nonzero) or out-of-page (address at or above 0x10000) addresses return 0. Writes to those addresses change no register.
- R11: Read data appears on the cycle after the read strobe and holds its value while no read is strobed.
- R12: A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is an out-of-page address whose low 16 bits match a live register, for example 0x10000 aliasing the control word at 0x0. A truncating decoder would quietly accept such a write. The stimulus writes distinctive patterns to aliased and unaligned addresses, then reads the real registers back and checks that they are unchanged. It also issues a read and a write to the same word in one cycle, on the control word whose write mirrors into the status word, to catch any bypass of the old value.

// File: rtl/cqv_cfg_pkg.sv
package cqv_cfg_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned OFF_W  = 16;

    localparam logic [OFF_W-1:0] OFF_CFG     = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_PARAM   = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_STAT    = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_VIERR0  = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_VIERR1  = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_VIMASK0 = 16'h001C;
    localparam logic [OFF_W-1:0] OFF_VIMASK1 = 16'h0020;
    localparam logic [OFF_W-1:0] OFF_QERR_LO = 16'h0024;
    localparam logic [OFF_W-1:0] OFF_QERR_HI = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_ALLOC   = 16'h0200;
    localparam logic [OFF_W-1:0] OFF_IFCFG   = 16'h1000;
    localparam logic [OFF_W-1:0] OFF_IFSTAT  = 16'h1004;
    localparam logic [OFF_W-1:0] OFF_MATCH   = 16'h1040;
    localparam logic [OFF_W-1:0] OFF_REPL    = 16'h1080;
    localparam logic [OFF_W-1:0] OFF_IFERR_LO = 16'h10C0;
    localparam logic [OFF_W-1:0] OFF_IFERR_HI = 16'h10CC;

    localparam int unsigned HYP_OWN_BIT = 17;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ZERO,
        RG_CFG,
        RG_PARAM,
        RG_STAT,
        RG_VIMASK,
        RG_ALLOC,
        RG_IFCFG,
        RG_IFSTAT,
        RG_MATCH,
        RG_REPL
    } region_e;
endpackage

// File: rtl/cqv_cfg_decode.sv
module cqv_cfg_decode
    import cqv_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned Q_LOG2   = 1,
    parameter int unsigned SID_LOG2 = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output region_e             region,
    output logic [SID_LOG2-1:0] idx
);
    localparam int unsigned NUM_Q   = 1 << Q_LOG2;
    localparam int unsigned NUM_SID = 1 << SID_LOG2;
    localparam logic [OFF_W-1:0] ALLOC_END = OFF_W'(OFF_ALLOC + 4 * NUM_Q);
    localparam logic [OFF_W-1:0] MATCH_END = OFF_W'(OFF_MATCH + 4 * NUM_SID);
    localparam logic [OFF_W-1:0] REPL_END  = OFF_W'(OFF_REPL + 4 * NUM_SID);

    logic [OFF_W-1:0] off;
    logic             in_page;

    always_comb begin
        off     = addr[OFF_W-1:0];
        in_page = (addr >> OFF_W) == '0;
        region  = RG_NONE;
        idx     = '0;
        if (in_page && off[1:0] == 2'b00) begin
            if (off == OFF_CFG) begin
                region = RG_CFG;
            end else if (off == OFF_PARAM) begin
                region = RG_PARAM;
            end else if (off == OFF_STAT) begin
                region = RG_STAT;
            end else if (off == OFF_VIERR0 || off == OFF_VIERR1) begin
                region = RG_ZERO;
            end else if (off == OFF_VIMASK0 || off == OFF_VIMASK1) begin
                region = RG_VIMASK;
                idx    = (off == OFF_VIMASK1) ? SID_LOG2'(1) : '0;
            end else if (off >= OFF_QERR_LO && off <= OFF_QERR_HI) begin
                region = RG_ZERO;
            end else if (off >= OFF_ALLOC && off < ALLOC_END) begin
                region = RG_ALLOC;
                idx    = SID_LOG2'((off - OFF_ALLOC) >> 2);
            end else if (off == OFF_IFCFG) begin
                region = RG_IFCFG;
            end else if (off == OFF_IFSTAT) begin
                region = RG_IFSTAT;
            end else if (off >= OFF_MATCH && off < MATCH_END) begin
                region = RG_MATCH;
                idx    = SID_LOG2'((off - OFF_MATCH) >> 2);
            end else if (off >= OFF_REPL && off < REPL_END) begin
                region = RG_REPL;
                idx    = SID_LOG2'((off - OFF_REPL) >> 2);
            end else if (off >= OFF_IFERR_LO && off <= OFF_IFERR_HI) begin
                region = RG_ZERO;
            end
        end
    end
endmodule

// File: rtl/cqv_sid_bank.sv
module cqv_sid_bank
    import cqv_cfg_pkg::*;
#(
    parameter int unsigned SID_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_match,
    input  logic                we_repl,
    input  logic [SID_LOG2-1:0] idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   match_rd,
    output logic [DATA_W-1:0]   repl_rd
);
    localparam int unsigned NUM_SID = 1 << SID_LOG2;

    logic [DATA_W-1:0] match_d [NUM_SID];
    logic [DATA_W-1:0] match_q [NUM_SID];
    logic [DATA_W-1:0] repl_d  [NUM_SID];
    logic [DATA_W-1:0] repl_q  [NUM_SID];

    for (genvar j = 0; j < NUM_SID; j++) begin : g_entry
        always_comb begin
            match_d[j] = match_q[j];
            repl_d[j]  = repl_q[j];
            if (we_match && idx == SID_LOG2'(j)) match_d[j] = wdata;
            if (we_repl  && idx == SID_LOG2'(j)) repl_d[j]  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SID; k++) begin
                match_q[k] <= '0;
                repl_q[k]  <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_SID; k++) begin
                match_q[k] <= match_d[k];
                repl_q[k]  <= repl_d[k];
            end
        end
    end

    assign match_rd = match_q[idx];
    assign repl_rd  = repl_q[idx];
endmodule

// File: rtl/cqv_cfg_regs.sv
module cqv_cfg_regs
    import cqv_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned VER      = 1,
    parameter int unsigned Q_LOG2   = 1,
    parameter int unsigned VI_LOG2  = 0,
    parameter int unsigned SID_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rdata
);
    localparam int unsigned NUM_Q = 1 << Q_LOG2;
    localparam logic [DATA_W-1:0] PARAM_VAL =
        {16'h0000, 4'(SID_LOG2), 4'(VI_LOG2), 4'(Q_LOG2), 4'(VER)};
    localparam logic [DATA_W-1:0] IFCFG_WMASK = ~(DATA_W'(1) << HYP_OWN_BIT);

    typedef struct packed {
        logic [DATA_W-1:0]            cfg;
        logic [1:0][DATA_W-1:0]       vimask;
        logic [NUM_Q-1:0][DATA_W-1:0] alloc;
        logic [DATA_W-1:0]            ifcfg;
        logic                         glb_on;
        logic                         if_on;
        logic [DATA_W-1:0]            rdata;
    } state_t;

    state_t              st_d, st_q;
    region_e             region;
    logic [SID_LOG2-1:0] idx;
    logic [DATA_W-1:0]   match_rd, repl_rd, rd_val;

    cqv_cfg_decode #(
        .ADDR_W  (ADDR_W),
        .Q_LOG2  (Q_LOG2),
        .SID_LOG2(SID_LOG2)
    ) u_dec (
        .addr  (addr),
        .region(region),
        .idx   (idx)
    );

    cqv_sid_bank #(
        .SID_LOG2(SID_LOG2)
    ) u_sid (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_match(wr_en && region == RG_MATCH),
        .we_repl (wr_en && region == RG_REPL),
        .idx     (idx),
        .wdata   (wdata),
        .match_rd(match_rd),
        .repl_rd (repl_rd)
    );

    // Read mux works on the registered state only, so a same-cycle write
    // is never visible to the read that accompanies it.
    always_comb begin
        unique case (region)
            RG_CFG:    rd_val = st_q.cfg;
            RG_PARAM:  rd_val = PARAM_VAL;
            RG_STAT:   rd_val = {31'b0, st_q.glb_on};
            RG_VIMASK: rd_val = st_q.vimask[idx[0]];
            RG_ALLOC:  rd_val = st_q.alloc[idx[Q_LOG2-1:0]];
            RG_IFCFG:  rd_val = st_q.ifcfg;
            RG_IFSTAT: rd_val = {31'b0, st_q.if_on};
            RG_MATCH:  rd_val = match_rd;
            RG_REPL:   rd_val = repl_rd;
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (region)
                RG_CFG: begin
                    st_d.cfg    = wdata;
                    st_d.glb_on = wdata[0];
                end
                RG_VIMASK: st_d.vimask[idx[0]] = wdata;
                RG_ALLOC:  st_d.alloc[idx[Q_LOG2-1:0]] = wdata;
                RG_IFCFG: begin
                    st_d.ifcfg = wdata & IFCFG_WMASK;
                    st_d.if_on = wdata[0];
                end
                default: ;
            endcase
        end
        if (rd_en) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/cqv_cfg_chk.sv
module cqv_cfg_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rdata
);
    logic out_page;
    assign out_page = (addr >> 16) != '0;

    p_param_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(32'h4)) |=> (rdata == 32'h0000_4011));

    p_status_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == '0) ##1 (rd_en && addr == ADDR_W'(32'h8))
        |=> (rdata == {31'b0, $past(wdata[0], 2)}));

    p_hyp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(32'h1000)) |=> (rdata[17] == 1'b0));

    p_ifstat_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(32'h1004)) |=> (rdata[31:1] == '0));

    p_out_page_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && out_page) |=> (rdata == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind cqv_cfg_regs cqv_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .wdata(wdata),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .rdata(rdata)
);

// File: tb/cqv_cfg_regs_test.sv
module cqv_cfg_regs_test;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    logic [31:0] mdl [int unsigned];
    logic [31:0] exp_rd = '0;

    always #2 clk = ~clk;

    cqv_cfg_regs uut (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .rdata(rdata)
    );

    function automatic logic [31:0] m_read(input logic [31:0] a);
        if (a >= 32'h10000 || a[1:0] != 2'b00) return '0;
        if (a == 32'h4) return 32'h0000_4011;
        if (mdl.exists(a)) return mdl[a];
        return '0;
    endfunction

    function automatic logic [31:0] m_mask(input logic [31:0] a);
        if (a >= 32'h10000 || a[1:0] != 2'b00) return '0;
        if (a == 32'h0 || a == 32'h1C || a == 32'h20) return '1;
        if (a == 32'h200 || a == 32'h204) return '1;
        if (a == 32'h1000) return 32'hFFFD_FFFF;
        if (a >= 32'h1040 && a < 32'h10C0) return '1;
        return '0;
    endfunction

    // Behavioural reference: reads see the state before this edge's write.
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl.delete();
            exp_rd = '0;
        end else begin
            if (rd_en) exp_rd = m_read(addr);
            if (wr_en) begin
                if (m_mask(addr) != '0) mdl[addr] = wdata & m_mask(addr);
                if (addr == 32'h0)    mdl[32'h8]    = {31'b0, wdata[0]};
                if (addr == 32'h1000) mdl[32'h1004] = {31'b0, wdata[0]};
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
        end
    end

    task automatic op(input logic [31:0] a, input logic [31:0] d,
                      input logic w, input logic r);
        @(negedge clk);
        addr = a; wdata = d; wr_en = w; rd_en = r;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        op(a, d, 1'b1, 1'b0);
    endtask

    task automatic rd(input logic [31:0] a);
        op(a, 32'hDEAD_BEEF, 1'b0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(32'h0, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        tag = "R1";  // reset values
        foreach (rst_list[i]) rd(rst_list[i]);
        idle(1);

        tag = "R2";
        rd(32'h4); wr(32'h4, 32'hFFFF_FFFF); rd(32'h4); idle(1);

        tag = "R3";
        wr(32'h0, 32'hA5F0_0F5B); rd(32'h0); rd(32'h8);
        wr(32'h8, 32'hFFFF_FFFE); rd(32'h8);
        wr(32'h0, 32'h0010_0000); rd(32'h8); rd(32'h0); idle(1);

        tag = "R4";
        wr(32'h1C, 32'h1234_5678); wr(32'h20, 32'h8765_4321);
        rd(32'h1C); rd(32'h20);
        for (int a = 32'h14; a <= 32'h30; a += 4)
            if (a != 32'h1C && a != 32'h20) wr(a, 32'hFFFF_FFFF);
        for (int a = 32'h14; a <= 32'h30; a += 4) rd(a);
        idle(1);

        tag = "R5";
        wr(32'h200, 32'h001F_80FF); wr(32'h204, 32'h0000_8003);
        rd(32'h200); rd(32'h204); idle(1);

        tag = "R6";
        wr(32'h1000, 32'hFFFF_FFFF); rd(32'h1000);
        wr(32'h1000, 32'h0002_0000); rd(32'h1000);
        wr(32'h1000, 32'h0001_FFFF); rd(32'h1000); idle(1);

        tag = "R7";
        rd(32'h1004); wr(32'h1004, 32'h00FF_000E); rd(32'h1004);
        wr(32'h1000, 32'h0000_0002); rd(32'h1004); idle(1);

        tag = "R8";
        for (int j = 0; j < 16; j++) begin
            wr(32'h1040 + 4 * j, 32'h0100_0001 * (j + 1));
            wr(32'h1080 + 4 * j, 32'h000F_F000 ^ j);
        end
        for (int j = 0; j < 16; j++) begin
            rd(32'h1040 + 4 * j);
            rd(32'h1080 + 4 * j);
        end
        idle(1);

        tag = "R9";
        for (int j = 0; j < 4; j++) wr(32'h10C0 + 4 * j, 32'hFFFF_FFFF);
        for (int j = 0; j < 4; j++) rd(32'h10C0 + 4 * j);
        idle(1);

        tag = "R10";  // aliases beyond the page, unaligned, unmapped
        wr(32'h0001_0000, 32'h0000_0001); wr(32'h0001_1000, 32'h0000_0001);
        wr(32'hFFFF_0200, 32'h0BAD_0BAD); wr(32'h0000_0202, 32'hCAFE_CAFE);
        wr(32'h0000_0100, 32'h7777_7777); wr(32'h0000_FFFC, 32'h5555_5555);
        rd(32'h0); rd(32'h8); rd(32'h1000); rd(32'h1004); rd(32'h200);
        rd(32'h0001_0000); rd(32'hFFFF_0200); rd(32'h0000_0202);
        rd(32'h0000_0100); rd(32'h0000_FFFC); rd(32'h0000_1100);
        idle(1);

        tag = "R11";  // hold while idle, also under writes
        rd(32'h1C); idle(3); wr(32'h1C, 32'h0F0F_0F0F); idle(2);
        rd(32'h1C); rd(32'h20); rd(32'h1C); idle(2);

        tag = "R12";
        op(32'h0, 32'h0000_0001, 1'b1, 1'b1); rd(32'h0);
        op(32'h8, 32'h0, 1'b0, 1'b1);
        op(32'h1040, 32'h1357_9BDF, 1'b1, 1'b1); rd(32'h1040);
        op(32'h1000, 32'h0003_0001, 1'b1, 1'b1); rd(32'h1004); rd(32'h1000);
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [31:0] rst_list [11] = '{32'h0, 32'h8, 32'h1C, 32'h20, 32'h200,
        32'h204, 32'h1000, 32'h1004, 32'h1040, 32'h1080, 32'h10C0};

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule